// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block turns single word read and write requests from an internal port into timed accesses on an external asynchronous memory bus. The request address is matched against four software-programmed address windows. The matching window's select line is driven for the whole access. Each access has three parts: a setup phase with address and select stable, a strobe phase, and a hold phase with the strobe released. Only after the hold phase does the requester see a one-cycle done pulse.

All external timing advances on an I/O tick, which is the core clock divided by 1, 2, 4, 16 or 32. Each window has its own configuration: a read wait count, a write wait count, a completion rule, and an 8/16-bit bus width. The completion rule combines the wait count with an acknowledge input that comes from outside the clock domain. On an 8-bit window a 16-bit word is moved as two byte accesses, low byte first. The strobe polarities are global settings. An address that hits no window is answered at once with an error.

Top module: `xbus_waitctl`

## Requirements
- R1: A request address A hits window b when A >= base_b and A - base_b < size_b, where size 0 never hits. Only `ext_sel[b]` is raised for the access. When windows overlap, the lowest index wins.
- R2: A request that hits no window gives `rsp_done` and `rsp_err` high together in the cycle after acceptance. No select or strobe is asserted.
- R3: Each byte or word access raises the select for exactly D core cycles before the strobe asserts, where D is the divide ratio. The select stays high for D cycles after the strobe drops. `rsp_done` pulses for one cycle in the cycle after that hold phase. The address is stable while the strobe is asserted.
- R4: In completion mode 0 (count only), the strobe lasts D*(W+1) core cycles. W is the window's read wait count for reads and its write wait count for writes. The acknowledge input has no effect in this mode.
- R5: In mode 1 (acknowledge only), the wait count is ignored and the strobe holds until the synchronized acknowledge is seen on a tick. With D=1 and acknowledge already high, the strobe lasts 1 cycle. When acknowledge rises during a stalled strobe, `rsp_done` follows 4 cycles later.
- R6: In mode 2, completion needs both the acknowledge and an exhausted count.
- R7: In mode 3, completion needs either the acknowledge or an exhausted count.
- R8: The divider code sets D: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 16, and 4 to 7 give 32.
- R9: On a window with the byte flag set, an access makes two byte accesses. The first uses `ext_addr` = {A,0} and the low byte, and the second uses {A,1} and the high byte. Write bytes appear on `ext_wdata[7:0]`. Read bytes are taken from `ext_rdata[7:0]` and assembled into `rsp_rdata`.
- R10: On a 16-bit window, `ext_addr` = {0,A}. The full write word is driven, and `rsp_rdata` returns `ext_rdata` as sampled at completion.
- R11: The read (write) strobe pin equals the read (write) polarity bit while that strobe is asserted, and its inverse at all other times.
- R12: `req_ready` is low from acceptance until the access ends. Configuration writes arriving in that time are discarded, so neither the current access nor later ones use those values.
- R13: After reset all windows have size 0, D=1 and both polarities are 0, so idle strobe pins are high. `req_ready` is high, and `ext_sel` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_we | input | 1 | Write one window configuration (idle only) |
| cfg_bank_idx | input | 2 | Window index written |
| cfg_base | input | AW | Window start address |
| cfg_size | input | AW | Window length in words |
| cfg_rwait | input | 4 | Read wait count |
| cfg_wwait | input | 4 | Write wait count |
| cfg_mode | input | 2 | Completion rule 0..3 |
| cfg_byte | input | 1 | 1 = 8-bit external bus |
| cfg_glob_we | input | 1 | Write divider and polarities (idle only) |
| cfg_div | input | 3 | Divider code |
| cfg_rd_pol | input | 1 | Read strobe asserted level |
| cfg_wr_pol | input | 1 | Write strobe asserted level |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Miss flag, valid with done |
| rsp_rdata | output | 16 | Read word, valid with done |
| ext_addr | output | AW+1 | External address |
| ext_sel | output | 4 | Window selects, active high |
| ext_rd | output | 1 | Read strobe pin |
| ext_wr | output | 1 | Write strobe pin |
| ext_wdata | output | 16 | External write data |
| ext_wdata_en | output | 1 | Write data drive enable |
| ext_rdata | input | 16 | External read data |
| ext_ack | input | 1 | Asynchronous acknowledge |

## Verification
A corrupted sequencer state shows up within one access as a wrong count of select or strobe cycles, or as a missing or late done pulse. A divider fault stretches every phase by a wrong multiple, so the latency counts expose it at the next request. A wrong window index or byte phase shows up as the wrong select line, address LSB or data byte within one strobe. Discarded configuration writes that leak in appear as changed strobe lengths on the following access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int WAIT_W = 4;
  parameter int DIV_W  = 3;

  typedef enum logic [1:0] {
    CMP_COUNT  = 2'd0,
    CMP_ACK    = 2'd1,
    CMP_BOTH   = 2'd2,
    CMP_EITHER = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [WAIT_W-1:0] rwait;
    logic [WAIT_W-1:0] wwait;
    cmp_mode_e         mode;
    logic              byte8;
  } win_tim_t;
endpackage

// File: rtl/xbus_tick_gen.sv
module xbus_tick_gen
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  localparam int CNT_W = 5;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (code)
      3'd0:    lim = 5'd0;
      3'd1:    lim = 5'd1;
      3'd2:    lim = 5'd3;
      3'd3:    lim = 5'd15;
      default: lim = 5'd31;
    endcase
  end

  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xbus_win_decode.sv
module xbus_win_decode #(
  parameter int NB    = 4,
  parameter int AW    = 16,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    base [NB],
  input  logic [AW-1:0]    size [NB],
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [NB-1:0] match;

  for (genvar b = 0; b < NB; b++) begin : g_win
    logic [AW-1:0] off;
    assign off      = addr - base[b];
    assign match[b] = (addr >= base[b]) && (off < size[b]);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (match[b]) idx = IDX_W'(b);
    end
  end
endmodule

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/xbus_waitctl.sv
module xbus_waitctl
  import xbus_pkg::*;
#(
  parameter int NB    = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bank_we,
  input  logic [IDX_W-1:0]  cfg_bank_idx,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_size,
  input  logic [WAIT_W-1:0] cfg_rwait,
  input  logic [WAIT_W-1:0] cfg_wwait,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_byte,
  input  logic              cfg_glob_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_rd_pol,
  input  logic              cfg_wr_pol,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW:0]       ext_addr,
  output logic [NB-1:0]     ext_sel,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [DW-1:0]     ext_wdata,
  output logic              ext_wdata_en,
  input  logic [DW-1:0]     ext_rdata,
  input  logic              ext_ack
);
  localparam int HW = DW / 2;

  // configuration storage
  logic [AW-1:0]    base_q [NB];
  logic [AW-1:0]    size_q [NB];
  win_tim_t         tim_q  [NB];
  logic [DIV_W-1:0] div_q;
  logic             rpol_q, wpol_q;

  // access state
  seq_st_e           st_q, st_d;
  logic              write_q, write_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic [IDX_W-1:0]  win_q, win_d;
  logic              phase_q, phase_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              busy, tick, ack_s, dec_hit, finish, cnt_zero, byte_mode;
  logic [IDX_W-1:0]  dec_idx;
  win_tim_t          cur;
  logic [WAIT_W-1:0] wait_sel;
  logic              rd_on, wr_on;

  assign busy = (st_q != ST_IDLE);

  xbus_tick_gen u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .code (div_q),
    .tick (tick)
  );

  xbus_win_decode #(.NB(NB), .AW(AW), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr),
    .base(base_q),
    .size(size_q),
    .hit (dec_hit),
    .idx (dec_idx)
  );

  xbus_sync #(.STAGES(2)) u_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_ack),
    .dout (ack_s)
  );

  // configuration registers: writes are dropped while an access runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        base_q[b] <= '0;
        size_q[b] <= '0;
        tim_q[b]  <= '0;
      end
      div_q  <= '0;
      rpol_q <= 1'b0;
      wpol_q <= 1'b0;
    end else begin
      if (cfg_bank_we && !busy) begin
        base_q[cfg_bank_idx]       <= cfg_base;
        size_q[cfg_bank_idx]       <= cfg_size;
        tim_q[cfg_bank_idx].rwait  <= cfg_rwait;
        tim_q[cfg_bank_idx].wwait  <= cfg_wwait;
        tim_q[cfg_bank_idx].mode   <= cmp_mode_e'(cfg_mode);
        tim_q[cfg_bank_idx].byte8  <= cfg_byte;
      end
      if (cfg_glob_we && !busy) begin
        div_q  <= cfg_div;
        rpol_q <= cfg_rd_pol;
        wpol_q <= cfg_wr_pol;
      end
    end
  end

  assign cur       = tim_q[win_q];
  assign byte_mode = cur.byte8;
  assign wait_sel  = write_q ? cur.wwait : cur.rwait;
  assign cnt_zero  = (cnt_q == '0);

  always_comb begin
    case (cur.mode)
      CMP_COUNT: finish = cnt_zero;
      CMP_ACK:   finish = ack_s;
      CMP_BOTH:  finish = ack_s && cnt_zero;
      default:   finish = ack_s || cnt_zero;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    write_d = write_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    win_d   = win_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (dec_hit) begin
            st_d    = ST_SETUP;
            write_d = req_write;
            addr_d  = req_addr;
            wdata_d = req_wdata;
            win_d   = dec_idx;
            phase_d = 1'b0;
          end else begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (tick) begin
          st_d  = ST_STRB;
          cnt_d = wait_sel;
        end
      end
      ST_STRB: begin
        if (tick) begin
          if (finish) begin
            st_d = ST_HOLD;
            if (!write_q) begin
              if (!byte_mode)   rdata_d = ext_rdata;
              else if (phase_q) rdata_d[DW-1:HW] = ext_rdata[HW-1:0];
              else              rdata_d[HW-1:0]  = ext_rdata[HW-1:0];
            end
          end else if (!cnt_zero) begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (byte_mode && !phase_q) begin
            phase_d = 1'b1;
            st_d    = ST_SETUP;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      win_q   <= '0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      win_q   <= win_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // external pins
  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign ext_sel[b] = busy && (win_q == IDX_W'(b));
  end

  assign rd_on        = (st_q == ST_STRB) && !write_q;
  assign wr_on        = (st_q == ST_STRB) &&  write_q;
  assign ext_rd       = rd_on ? rpol_q : ~rpol_q;
  assign ext_wr       = wr_on ? wpol_q : ~wpol_q;
  assign ext_addr     = byte_mode ? {addr_q, phase_q} : {1'b0, addr_q};
  assign ext_wdata    = !byte_mode ? wdata_q
                      : (phase_q ? {{HW{1'b0}}, wdata_q[DW-1:HW]}
                                 : {{HW{1'b0}}, wdata_q[HW-1:0]});
  assign ext_wdata_en = busy && write_q;

  assign req_ready = !busy;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xbus_waitctl_chk.sv
module xbus_waitctl_chk #(
  parameter int NB = 4,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] ext_sel,
  input logic          rd_on,
  input logic          wr_on,
  input logic [AW:0]   ext_addr,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_err
);
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_sel));

  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> ($past(ext_sel) == '0 && !$past(rd_on || wr_on)));

  a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_on || wr_on) |-> ($past(ext_sel) != '0));

  a_r3_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_on || wr_on) |-> (ext_sel != '0));

  a_r3_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on || wr_on) |-> (ext_sel != '0));

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && ext_sel == '0));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_on || wr_on) && $past(rd_on || wr_on)) |-> $stable(ext_addr));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_on && wr_on));

  a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel != '0) |-> !req_ready);
endmodule

bind xbus_waitctl xbus_waitctl_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_sel  (ext_sel),
  .rd_on    (rd_on),
  .wr_on    (wr_on),
  .ext_addr (ext_addr),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .rsp_err  (rsp_err)
);

// File: tb/sim_xbus_waitctl.sv
`timescale 1ns/1ps
module sim_xbus_waitctl;
  localparam int AW = 16;

  logic        clk, rst_n;
  logic        cfg_bank_we, cfg_byte, cfg_glob_we, cfg_rd_pol, cfg_wr_pol;
  logic [1:0]  cfg_bank_idx, cfg_mode;
  logic [15:0] cfg_base, cfg_size;
  logic [3:0]  cfg_rwait, cfg_wwait;
  logic [2:0]  cfg_div;
  logic        req_valid, req_write, req_ready, rsp_done, rsp_err;
  logic [15:0] req_addr, req_wdata, rsp_rdata;
  logic [16:0] ext_addr;
  logic [3:0]  ext_sel;
  logic        ext_rd, ext_wr, ext_wdata_en, ext_ack;
  logic [15:0] ext_wdata, ext_rdata;

  xbus_waitctl u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] memf(input logic [16:0] a);
    return (a[15:0] * 16'd40503) ^ 16'h5AC3 ^ {15'd0, a[16]};
  endfunction
  assign ext_rdata = memf(ext_addr);

  int nchk = 0, nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int divf(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 16;
      default: return 32;
    endcase
  endfunction

  // expected configuration mirror
  int  base_e [4], size_e [4];
  bit  rp_e = 0, wp_e = 0;

  function automatic int exp_win(input int a);
    for (int b = 0; b < 4; b++)
      if (a >= base_e[b] && (a - base_e[b]) < size_e[b]) return b;
    return -1;
  endfunction

  task automatic cfg_win(input int idx, input int base, input int size, input int rw,
                         input int ww, input int mode, input bit byt);
    @(negedge clk);
    cfg_bank_we = 1; cfg_bank_idx = 2'(idx); cfg_base = 16'(base); cfg_size = 16'(size);
    cfg_rwait = 4'(rw); cfg_wwait = 4'(ww); cfg_mode = 2'(mode); cfg_byte = byt;
    @(negedge clk);
    cfg_bank_we = 0;
    base_e[idx] = base; size_e[idx] = size;
  endtask

  task automatic cfg_glob(input int dv, input bit rp, input bit wp);
    @(negedge clk);
    cfg_glob_we = 1; cfg_div = 3'(dv); cfg_rd_pol = rp; cfg_wr_pol = wp;
    @(negedge clk);
    cfg_glob_we = 0;
    rp_e = rp; wp_e = wp;
  endtask

  // measurement results
  int          m_lat, m_sel, m_strb, m_nph;
  logic [3:0]  m_selv;
  logic [16:0] m_a [2];
  logic [15:0] m_w [2];
  logic [15:0] m_rd;
  bit          m_err, m_other, m_busy_ready;

  task automatic launch(input bit wr, input int addr, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 16'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  // counts from the first sample after acceptance until the done pulse
  task automatic measure(input bit wr, input bit first_seen);
    bit st, prev;
    m_lat = 1; m_sel = 0; m_strb = 0; m_nph = 0; m_selv = 0; m_other = 0;
    m_busy_ready = 0; prev = 0;
    for (int i = 0; i < 20000; i++) begin
      if (i > 0) @(negedge clk);
      if (i > 0) m_lat++;
      if (rsp_done) begin
        m_err = rsp_err; m_rd = rsp_rdata;
        return;
      end
      st = wr ? (ext_wr == wp_e) : (ext_rd == rp_e);
      if ((wr ? ext_rd : ext_wr) != (wr ? !rp_e : !wp_e)) m_other = 1;
      if (ext_sel != 0) begin
        m_sel++;
        if (m_selv == 0) m_selv = ext_sel;
        if (req_ready) m_busy_ready = 1;
      end
      if (st) m_strb++;
      if (st && !prev && m_nph < 2) begin
        m_a[m_nph] = ext_addr; m_w[m_nph] = ext_wdata; m_nph++;
      end
      prev = st;
    end
    chk(0, "R3 done never seen", 0, 1);
    if (first_seen) m_err = 0;
  endtask

  task automatic access(input bit wr, input int addr, input logic [15:0] wd);
    launch(wr, addr, wd);
    measure(wr, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_ack = 0;
    cfg_bank_we = 0; cfg_bank_idx = 0; cfg_base = 0; cfg_size = 0; cfg_rwait = 0;
    cfg_wwait = 0; cfg_mode = 0; cfg_byte = 0; cfg_glob_we = 0; cfg_div = 0;
    cfg_rd_pol = 0; cfg_wr_pol = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    for (int b = 0; b < 4; b++) begin base_e[b] = 0; size_e[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R13 reset state
    chk(req_ready == 1, "R13 ready", req_ready, 1);
    chk(ext_sel == 0, "R13 sel", ext_sel, 0);
    chk(ext_rd == 1 && ext_wr == 1, "R13 strobes idle high", {ext_rd, ext_wr}, 3);
    chk(rsp_done == 0, "R13 done", rsp_done, 0);
    access(0, 16'h0040, 0);
    chk(m_err == 1 && m_lat == 1, "R13 all windows empty", {m_err, 8'(m_lat)}, 16'h101);

    // R1 / R2 window decode and priority, misses
    cfg_win(0, 16'h0100, 16'h0100, 0, 0, 0, 0);
    cfg_win(1, 16'h0180, 16'h0200, 0, 0, 0, 0);
    cfg_win(2, 16'h1000, 16'h0010, 0, 0, 0, 0);
    cfg_win(3, 16'h2000, 16'h0001, 0, 0, 0, 0);
    begin
      int tst [12] = '{16'h00FF, 16'h0100, 16'h0180, 16'h01FF, 16'h0200, 16'h037F,
                       16'h0380, 16'h1000, 16'h100F, 16'h1010, 16'h2000, 16'h2001};
      foreach (tst[i]) begin
        int eb;
        eb = exp_win(tst[i]);
        access(0, tst[i], 0);
        if (eb < 0) begin
          chk(m_err == 1, "R2 miss flags error", m_err, 1);
          chk(m_lat == 1, "R2 miss latency", m_lat, 1);
          chk(m_sel == 0 && m_strb == 0, "R2 miss no select/strobe", m_sel + m_strb, 0);
        end else begin
          chk(m_err == 0, "R1 hit no error", m_err, 0);
          chk(m_selv == 4'(1 << eb), "R1 select line", m_selv, 1 << eb);
        end
      end
    end

    // R3 R4 R8 R10 sweep: divider code x wait x direction, count mode
    cfg_win(0, 0, 16'h0100, 0, 0, 0, 0);
    for (int dc = 0; dc < 8; dc++) begin
      cfg_glob(dc, 0, 0);
      foreach (base_e[k]) ; // keep mirror
      for (int wi = 0; wi < 4; wi++) begin
        int wv, rw, ww;
        wv = (wi == 0) ? 0 : (wi == 1) ? 2 : (wi == 2) ? 5 : 15;
        rw = wv; ww = (wv + 3) % 16;
        cfg_win(0, 0, 16'h0100, rw, ww, 0, 0);
        for (int wr = 0; wr < 2; wr++) begin
          int d, k, a;
          logic [15:0] wd;
          d = divf(dc); k = (wr ? ww : rw) + 1;
          a = 16'h0011 + dc * 8 + wi * 2 + wr;
          wd = 16'(16'hC3A5 ^ (a * 16'd257));
          access(wr[0], a, wd);
          chk(m_strb == d * k, "R4 R8 strobe length", m_strb, d * k);
          chk(m_sel == d * (k + 2), "R3 select span", m_sel, d * (k + 2));
          chk(m_lat == d * (k + 2) + 1, "R3 done timing", m_lat, d * (k + 2) + 1);
          chk(m_a[0] == {1'b0, 16'(a)}, "R10 word address", m_a[0], a);
          if (wr) chk(m_w[0] == wd, "R10 write word", m_w[0], wd);
          else    chk(m_rd == memf({1'b0, 16'(a)}), "R10 read word", m_rd, memf({1'b0, 16'(a)}));
        end
      end
    end

    // R11 polarity combinations
    cfg_win(0, 0, 16'h0100, 1, 2, 0, 0);
    for (int p = 0; p < 4; p++) begin
      cfg_glob(0, p[0], p[1]);
      @(negedge clk);
      chk(ext_rd == !p[0] && ext_wr == !p[1], "R11 idle levels", {ext_rd, ext_wr}, {!p[0], !p[1]});
      access(0, 16'h0020, 0);
      chk(m_strb == 2 && !m_other, "R11 read strobe level", m_strb, 2);
      access(1, 16'h0021, 16'h1234);
      chk(m_strb == 3 && !m_other, "R11 write strobe level", m_strb, 3);
    end
    cfg_glob(0, 0, 0);

    // R9 byte mode on window 2, divide by 2
    cfg_glob(1, 0, 0);
    cfg_win(2, 16'h1000, 16'h0010, 1, 1, 0, 1);
    for (int i = 0; i < 3; i++) begin
      int a;
      logic [15:0] wd, er;
      a = 16'h1003 + i * 5;
      wd = 16'(16'hB7C1 + i * 16'h1111);
      access(1, a, wd);
      chk(m_nph == 2, "R9 two byte writes", m_nph, 2);
      chk(m_a[0] == {16'(a), 1'b0} && m_a[1] == {16'(a), 1'b1}, "R9 byte addresses",
          {m_a[0], m_a[1]}, {16'(a), 1'b0, 16'(a), 1'b1});
      chk(m_w[0] == {8'h00, wd[7:0]} && m_w[1] == {8'h00, wd[15:8]}, "R9 write bytes low first",
          {m_w[0], m_w[1]}, {8'h00, wd[7:0], 8'h00, wd[15:8]});
      chk(m_lat == 2 * 2 * 4 + 1, "R9 byte timing", m_lat, 17);
      access(0, a, 0);
      er = {memf({16'(a), 1'b1})[7:0], memf({16'(a), 1'b0})[7:0]};
      chk(m_rd == er, "R9 read assembly", m_rd, er);
    end
    cfg_glob(0, 0, 0);

    // R4 R5 R6 R7 completion rules with a steady acknowledge, D=1, wait 3
    for (int md = 0; md < 4; md++) begin
      for (int ak = 0; ak < 2; ak++) begin
        int ex;
        if ((md == 1 || md == 2) && ak == 0) continue;
        cfg_win(0, 0, 16'h0100, 3, 3, md, 0);
        ext_ack = ak[0];
        repeat (4) @(negedge clk);
        access(0, 16'h0030, 0);
        ex = (md == 0) ? 4 : (md == 1) ? 1 : (md == 2) ? 4 : (ak ? 1 : 4);
        if (md == 0) chk(m_strb == ex, "R4 ack ignored", m_strb, ex);
        if (md == 1) chk(m_strb == ex, "R5 ack only", m_strb, ex);
        if (md == 2) chk(m_strb == ex, "R6 ack and count", m_strb, ex);
        if (md == 3) chk(m_strb == ex, "R7 ack or count", m_strb, ex);
        ext_ack = 0;
        repeat (4) @(negedge clk);
      end
    end

    // R5 R6 stall until acknowledge arrives
    for (int md = 1; md < 3; md++) begin
      int n;
      cfg_win(0, 0, 16'h0100, 0, 0, md, 0);
      launch(0, 16'h0031, 0);
      repeat (40) @(negedge clk);
      if (md == 1) chk(ext_rd == 0 && ext_sel == 1, "R5 stalls without ack", {ext_rd, ext_sel}, 1);
      else         chk(ext_rd == 0 && ext_sel == 1, "R6 stalls without ack", {ext_rd, ext_sel}, 1);
      ext_ack = 1;
      n = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        n++;
        if (rsp_done) break;
      end
      if (md == 1) chk(n == 4, "R5 done after ack", n, 4);
      else         chk(n == 4, "R6 done after ack", n, 4);
      ext_ack = 0;
      repeat (4) @(negedge clk);
    end

    // R12 configuration writes during an access are discarded
    cfg_win(0, 0, 16'h0100, 15, 15, 0, 0);
    launch(0, 16'h0044, 0);
    fork
      measure(0, 1'b1);
      begin
        repeat (3) @(negedge clk);
        cfg_bank_we = 1; cfg_bank_idx = 0; cfg_base = 0; cfg_size = 16'h0100;
        cfg_rwait = 0; cfg_wwait = 0; cfg_mode = 0; cfg_byte = 0;
        cfg_glob_we = 1; cfg_div = 3'd4; cfg_rd_pol = 1; cfg_wr_pol = 1;
        @(negedge clk);
        cfg_bank_we = 0; cfg_glob_we = 0;
      end
    join
    chk(m_strb == 16, "R12 current access unchanged", m_strb, 16);
    chk(!m_busy_ready, "R12 ready low while busy", m_busy_ready, 0);
    access(0, 16'h0045, 0);
    chk(m_strb == 16 && m_lat == 19, "R12 later access unchanged", m_strb, 16);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule